// File: doc/BRIEF.md
# Serial Engine Interrupt Status and Watermark Controller

This block gathers the interrupt sources on the master side of a serial engine into one status register. It drives a single interrupt line from the status bits that the enable mask lets through. Short events are captured on the cycle their pulse arrives and stay set until software clears them. There are eleven of them: command done, cancel done, abort done, receive last, and seven error conditions. Software clears status bits by writing ones to a clear register. Writing back a status word it has just read clears everything it handled.

Two status bits are not events but levels, and they are derived from FIFO fill counts. The transmit watermark bit tracks whether the transmit FIFO has drained to a programmed level. The receive watermark bit tracks whether the receive FIFO has filled to its level. Both keep setting themselves for as long as their condition holds, so clearing one only sticks once the condition has gone away. A ready-for-receive output, derived from a third threshold, tells the upstream side whether the receive FIFO still has room.

Top module: `seirq_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the status to 0, drives `irq_o` and `rx_rdy_o` low, clears the enable mask, and sets the transmit level to 0. It also sets the receive watermark level to DEPTH-3 and the ready-for-receive level to DEPTH-2.
- R2: A one on `evt_i[k]` (k = 0..10) at a clock edge sets `status_o[k]` at that edge. The bit stays set after the pulse ends. Bit map: 0 command done, 1 cancel done, 2 abort done, 3 receive last, 4..10 the errors (command overrun, illegal command, command failure, rx read, rx write, tx read, tx write).
- R3: A configuration write with `cfg_sel`=1 clears every status bit whose `cfg_wdata` bit is 1 and leaves the others alone. Event bits that are cleared stay clear until a new pulse arrives, so writing back a read status value clears exactly those bits.
- R4: If an event pulse and a clear of the same bit land on one edge, the bit ends up set.
- R5: `status_o[11]` (transmit watermark) sets at each edge where the transmit level is nonzero and `tx_fill_i` is less than or equal to it. A clear issued while that holds does not remove the bit. A clear issued after the fill has risen above the level does remove it.
- R6: With the transmit level at 0 (`cfg_sel`=2), `status_o[11]` never sets, whatever the fill.
- R7: `status_o[12]` (receive watermark) sets at each edge where `rx_fill_i` is nonzero and at least the receive watermark level (`cfg_sel`=3). Like bit 11, it re-sets after a clear while its condition holds.
- R8: One edge after any cycle, `rx_rdy_o` equals (`rx_fill_i` < ready-for-receive level) as sampled in that cycle. The level is set with `cfg_sel`=4.
- R9: `irq_o` equals the OR of (`status_o` AND enable mask), and it updates on the same edge as `status_o`. A masked bit alone never raises `irq_o`.
- R10: A write to the enable mask (`cfg_sel`=0) takes effect on `irq_o` at the edge of the write. A level register written at edge k is first compared at edge k+1.

Parameter defaults: DEPTH=16, DATAW=16; fill and level fields are $clog2(DEPTH+1) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 11 | Single-cycle event pulses, bit map in R2 |
| tx_fill_i | input | LVLW | Transmit FIFO fill count |
| rx_fill_i | input | LVLW | Receive FIFO fill count |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0 enable, 1 clear, 2 tx level, 3 rx level, 4 ready level |
| cfg_wdata | input | DATAW | Write data (low bits used) |
| status_o | output | 13 | Registered status word |
| irq_o | output | 1 | Registered interrupt line |
| rx_rdy_o | output | 1 | Registered ready-for-receive flag |

## Verification
The status word is a port, so a stuck, lost or spurious status bit shows on the edge right after the stimulus that should have moved it. A wrong enable mask shows up on `irq_o` at that same edge. A wrong level comparison, or a stored threshold that was corrupted, shows up on bit 11 or bit 12 one edge after the fill count crosses the boundary. The fill is stepped exactly to each threshold and one past it. A clear that should lose to a held level, or to a simultaneous event, is read back on the next edge.

// File: rtl/seirq_pkg.sv
package seirq_pkg;
  // status word layout: event bits first, then the two level bits
  localparam int NEVT    = 11;
  localparam int NSRC    = 13;
  localparam int B_TXWM  = 11;
  localparam int B_RXWM  = 12;

  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_CLR  = 3'd1,
    SEL_TXWM = 3'd2,
    SEL_RXWM = 3'd3,
    SEL_RFR  = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/seirq_cfg.sv
module seirq_cfg
  import seirq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVLW  = 5,
  parameter int DATAW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [DATAW-1:0] wdata,
  output logic [NSRC-1:0]  en_next,
  output logic [NSRC-1:0]  en_q,
  output logic [NSRC-1:0]  clr_mask,
  output logic [LVLW-1:0]  tx_wm_q,
  output logic [LVLW-1:0]  rx_wm_q,
  output logic [LVLW-1:0]  rfr_q
);
  localparam logic [LVLW-1:0] RXWM_RST = LVLW'(DEPTH - 3);
  localparam logic [LVLW-1:0] RFR_RST  = LVLW'(DEPTH - 2);

  logic [NSRC-1:0] wd_src;
  logic [LVLW-1:0] wd_lvl;

  assign wd_src = wdata[NSRC-1:0];
  assign wd_lvl = wdata[LVLW-1:0];

  always_comb begin
    en_next  = en_q;
    clr_mask = '0;
    if (we && sel == SEL_EN)  en_next  = wd_src;
    if (we && sel == SEL_CLR) clr_mask = wd_src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      tx_wm_q <= '0;
      rx_wm_q <= RXWM_RST;
      rfr_q   <= RFR_RST;
    end else begin
      en_q <= en_next;
      if (we && sel == SEL_TXWM) tx_wm_q <= wd_lvl;
      if (we && sel == SEL_RXWM) rx_wm_q <= wd_lvl;
      if (we && sel == SEL_RFR)  rfr_q   <= wd_lvl;
    end
  end
endmodule

// File: rtl/seirq_lvl.sv
module seirq_lvl #(
  parameter int LVLW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LVLW-1:0] tx_fill,
  input  logic [LVLW-1:0] rx_fill,
  input  logic [LVLW-1:0] tx_wm,
  input  logic [LVLW-1:0] rx_wm,
  input  logic [LVLW-1:0] rfr,
  output logic [1:0]      hit,
  output logic            rx_rdy
);
  // hit[0]: transmit drained to level (level 0 disables)
  // hit[1]: receive filled to level (empty FIFO never hits)
  assign hit[0] = (tx_wm != '0) && (tx_fill <= tx_wm);
  assign hit[1] = (rx_fill != '0) && (rx_fill >= rx_wm);

  always_ff @(posedge clk) begin
    if (rst) rx_rdy <= 1'b0;
    else     rx_rdy <= (rx_fill < rfr);
  end
endmodule

// File: rtl/seirq_stat.sv
module seirq_stat
  import seirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] evt,
  input  logic [1:0]      lvl_hit,
  input  logic [NSRC-1:0] clr_mask,
  input  logic [NSRC-1:0] en_next,
  output logic [NSRC-1:0] status,
  output logic            irq
);
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] st_next;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (i < NEVT) begin : g_edge
      assign set_v[i] = evt[i];
    end else begin : g_level
      assign set_v[i] = lvl_hit[i-NEVT];
    end
    // a source that fires on the clearing edge wins over the clear
    assign st_next[i] = (status[i] & ~clr_mask[i]) | set_v[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= st_next;
      irq    <= |(st_next & en_next);
    end
  end
endmodule

// File: rtl/seirq_ctrl.sv
module seirq_ctrl
  import seirq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATAW = 16,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [10:0]      evt_i,
  input  logic [LVLW-1:0]  tx_fill_i,
  input  logic [LVLW-1:0]  rx_fill_i,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [DATAW-1:0] cfg_wdata,
  output logic [12:0]      status_o,
  output logic             irq_o,
  output logic             rx_rdy_o
);
  logic [NSRC-1:0] en_next, en_q, clr_mask;
  logic [LVLW-1:0] tx_wm_q, rx_wm_q, rfr_q;
  logic [1:0]      lvl_hit;

  seirq_cfg #(.DEPTH(DEPTH), .LVLW(LVLW), .DATAW(DATAW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .en_next(en_next), .en_q(en_q), .clr_mask(clr_mask),
    .tx_wm_q(tx_wm_q), .rx_wm_q(rx_wm_q), .rfr_q(rfr_q)
  );

  seirq_lvl #(.LVLW(LVLW)) u_lvl (
    .clk(clk), .rst(rst), .tx_fill(tx_fill_i), .rx_fill(rx_fill_i),
    .tx_wm(tx_wm_q), .rx_wm(rx_wm_q), .rfr(rfr_q),
    .hit(lvl_hit), .rx_rdy(rx_rdy_o)
  );

  seirq_stat u_stat (
    .clk(clk), .rst(rst), .evt(evt_i), .lvl_hit(lvl_hit),
    .clr_mask(clr_mask), .en_next(en_next),
    .status(status_o), .irq(irq_o)
  );
endmodule

// File: rtl/seirq_ctrl_chk.sv
module seirq_ctrl_chk #(
  parameter int LVLW = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [10:0]     evt_i,
  input logic [LVLW-1:0] tx_fill_i,
  input logic [LVLW-1:0] rx_fill_i,
  input logic [12:0]     status_o,
  input logic            irq_o,
  input logic            rx_rdy_o,
  input logic [12:0]     en_q,
  input logic [LVLW-1:0] tx_wm_q,
  input logic [LVLW-1:0] rfr_q
);
  // R2: every pulsed event is visible in the status word one edge later
  a_r2_evt_sets: assert property (@(posedge clk) disable iff (rst)
    (!rst && evt_i != '0) |=> ((status_o[10:0] & $past(evt_i)) == $past(evt_i)));

  // R3: an event bit never rises without a pulse
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((status_o[10:0] & ~$past(status_o[10:0]) & ~$past(evt_i)) == '0));

  // R5: drained transmit FIFO below a nonzero level sets bit 11
  a_r5_txwm_sets: assert property (@(posedge clk) disable iff (rst)
    (!rst && tx_wm_q != '0 && tx_fill_i <= tx_wm_q) |=> status_o[11]);

  // R6: disabled transmit level keeps a clear bit 11 clear
  a_r6_txwm_off: assert property (@(posedge clk) disable iff (rst)
    (!rst && tx_wm_q == '0 && !status_o[11]) |=> !status_o[11]);

  // R8: ready flag follows the previous cycle's comparison
  a_r8_rdy: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (rx_rdy_o == $past(rx_fill_i < rfr_q)));

  // R9: interrupt line agrees with the masked status
  a_r9_irq: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_o & en_q));
endmodule

bind seirq_ctrl seirq_ctrl_chk #(.LVLW(LVLW)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .tx_fill_i(tx_fill_i),
  .rx_fill_i(rx_fill_i), .status_o(status_o), .irq_o(irq_o),
  .rx_rdy_o(rx_rdy_o), .en_q(en_q), .tx_wm_q(tx_wm_q), .rfr_q(rfr_q)
);

// File: tb/seirq_ctrl_test.sv
module seirq_ctrl_test;
  localparam int DEPTH = 16;
  localparam int DATAW = 16;
  localparam int LVLW  = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst;
  logic [10:0]      evt_i;
  logic [LVLW-1:0]  tx_fill_i, rx_fill_i;
  logic             cfg_we;
  logic [2:0]       cfg_sel;
  logic [DATAW-1:0] cfg_wdata;
  logic [12:0]      status_o;
  logic             irq_o, rx_rdy_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [12:0] st;
    logic        irq;
    logic        rdy;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  seirq_ctrl #(.DEPTH(DEPTH), .DATAW(DATAW)) uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .tx_fill_i(tx_fill_i),
    .rx_fill_i(rx_fill_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .status_o(status_o), .irq_o(irq_o),
    .rx_rdy_o(rx_rdy_o)
  );

  // monitor: compares the outputs after each edge with the queued expectation
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (status_o !== e.st || irq_o !== e.irq || rx_rdy_o !== e.rdy) begin
        n_fail++;
        $display("FAIL %s: status=%h irq=%b rdy=%b expected status=%h irq=%b rdy=%b",
                 e.tag, status_o, irq_o, rx_rdy_o, e.st, e.irq, e.rdy);
      end
    end
  end

  // driver: one clock edge, then queue what that edge must produce
  task automatic tick(input string tag, input logic [12:0] st,
                      input logic irq, input logic rdy);
    exp_t e;
    @(posedge clk);
    e.tag = tag; e.st = st; e.irq = irq; e.rdy = rdy;
    sb.push_back(e);
    @(negedge clk);
    evt_i  = '0;
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [DATAW-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
  endtask

  initial begin
    rst = 1'b1; evt_i = '0; tx_fill_i = '0; rx_fill_i = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    @(negedge clk);
    tick("R1 reset", 13'h000, 0, 0);
    tick("R1 reset", 13'h000, 0, 0);
    rst = 1'b0;
    tick("R8 empty rx ready", 13'h000, 0, 1);

    evt_i = 11'h001;
    tick("R2 cmd done captured", 13'h001, 0, 1);
    tick("R2 cmd done held", 13'h001, 0, 1);
    wr(3'd0, 16'h1FFF);
    tick("R10 enable same edge", 13'h001, 1, 1);
    wr(3'd1, 16'h0001);
    tick("R3 clear", 13'h000, 0, 1);
    tick("R3 stays clear", 13'h000, 0, 1);

    evt_i = 11'h040; wr(3'd1, 16'h0040);
    tick("R4 event beats clear", 13'h040, 1, 1);
    wr(3'd1, 16'h0040);
    tick("R4 later clear", 13'h000, 0, 1);

    wr(3'd0, 16'h1FFE);
    tick("R9 mask write", 13'h000, 0, 1);
    evt_i = 11'h001;
    tick("R9 masked bit no irq", 13'h001, 0, 1);
    wr(3'd1, 16'h0001);
    tick("R9 clear", 13'h000, 0, 1);
    wr(3'd0, 16'h1FFF);
    tick("R10 unmask", 13'h000, 0, 1);

    tx_fill_i = 5'd8; wr(3'd2, 16'd4);
    tick("R5 above level", 13'h000, 0, 1);
    tx_fill_i = 5'd4;
    tick("R5 at level sets", 13'h800, 1, 1);
    wr(3'd1, 16'h0800);
    tick("R5 re-asserts while held", 13'h800, 1, 1);
    tx_fill_i = 5'd5; wr(3'd1, 16'h0800);
    tick("R5 clear sticks", 13'h000, 0, 1);

    wr(3'd2, 16'd0);
    tick("R6 disable write", 13'h000, 0, 1);
    tx_fill_i = 5'd0;
    tick("R6 disabled empty", 13'h000, 0, 1);
    tick("R6 disabled hold", 13'h000, 0, 1);

    rx_fill_i = 5'd13;
    tick("R7 default level", 13'h1000, 1, 1);
    rx_fill_i = 5'd14; wr(3'd1, 16'h1000);
    tick("R7 re-asserts, R8 full", 13'h1000, 1, 0);
    rx_fill_i = 5'd12; wr(3'd1, 16'h1000);
    tick("R7 below level", 13'h000, 0, 1);
    wr(3'd3, 16'd2);
    tick("R10 level not yet used", 13'h000, 0, 1);
    tick("R7 new level", 13'h1000, 1, 1);
    rx_fill_i = 5'd0; wr(3'd1, 16'h1000);
    tick("R7 empty never hits", 13'h000, 0, 1);

    wr(3'd4, 16'd3);
    tick("R8 level write", 13'h000, 0, 1);
    rx_fill_i = 5'd3;
    tick("R8 at level not ready", 13'h1000, 1, 0);
    rx_fill_i = 5'd2;
    tick("R8 below level ready", 13'h1000, 1, 1);

    rx_fill_i = 5'd0; evt_i = 11'h7FF;
    tick("R2 all events", 13'h17FF, 1, 1);
    wr(3'd1, 16'h17FF);
    tick("R3 write-back clear", 13'h000, 0, 1);

    @(negedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule